// File: doc/BRIEF.md
# Dual-Half Readout Receive FIFO

This block buffers 32-bit words arriving from one serial receive channel and lets a host collect them over a 16-bit parallel bus. Each time the deserializer finishes a word it raises a one-cycle store strobe with the word alongside, and the word goes into a queue of up to 32 entries.

The host fetches each word in two enable pulses. An enable with the half-select line low returns the lower half of the oldest word and leaves it queued. An enable with the half-select line high returns the upper half and retires the word. Three active-low flags tell the host what the queue holds: data waiting, at least half full, and full.

When the queue is full, a new word is not dropped. It replaces the most recently stored entry, so the older entries are kept intact.

Top module: `rxq_dual_half_fifo`

## Requirements
- R1: After reset all three flags are high (inactive), the read data output is zero and the queue is empty.
- R2: The clock edge that samples a store strobe leaves the data-ready flag low (asserted).
- R3: An enable pulse with half-select low on a non-empty queue puts bits [15:0] of the oldest word on the read data output after that edge, and does not remove the word.
- R4: An enable pulse with half-select high on a non-empty queue puts bits [31:16] of the oldest word on the read data output after that edge, and removes that word.
- R5: Words leave the queue in the order they were stored.
- R6: The half-full flag is low exactly when the queue holds 16 or more words.
- R7: The full flag is low exactly when the queue holds 32 words, and occupancy never exceeds 32.
- R8: A store strobe while the queue is full and no word is removed in the same cycle overwrites the newest entry. Occupancy stays at 32 and the older 31 entries are unchanged.
- R9: An enable pulse on an empty queue leaves the read data output unchanged and moves no pointer.
- R10: A store and a word removal in the same cycle leave the occupancy unchanged.
- R11: The data-ready flag returns high only after the upper half of the last queued word has been read, leaving the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_i | input | 1 | One-cycle strobe: a received word is complete |
| store_word_i | input | 32 | Received word, valid with store_i |
| rd_en_i | input | 1 | One-cycle host read enable |
| half_sel_i | input | 1 | 0 selects the lower half, 1 selects the upper half and retires the word |
| rd_data_o | output | 16 | Registered half word for the host |
| ready_n_o | output | 1 | Low while at least one word is queued |
| half_full_n_o | output | 1 | Low while 16 or more words are queued |
| full_n_o | output | 1 | Low while 32 words are queued |

## Verification
The bench builds the block with its default parameters: 32 entries, 32-bit words and a half-full level of 16. At these values the queue can be filled to the half-full threshold, to capacity, and into repeated overwrites of the newest slot within a few hundred cycles. The same run also covers simultaneous store and removal at both the 16-word edge and the 32-word edge, and reads against an empty queue after draining.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DEPTH  = 32;
    localparam int RXQ_WORD_W = 32;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [PW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [PW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH    = 32,
    parameter int HF_LEVEL = 16,
    localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_i,
    input  logic          rd_en_i,
    input  logic          half_sel_i,
    output logic          we_o,
    output logic [PW-1:0] waddr_o,
    output logic [PW-1:0] raddr_o,
    output logic          rd_ok_o,
    output logic          ready_n_o,
    output logic          half_full_n_o,
    output logic          full_n_o
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ready_n;
        logic          hf_n;
        logic          full_n;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  empty_w, full_w, pop_w, ovw_w, adv_w;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        empty_w = (st_q.cnt == '0);
        full_w  = (st_q.cnt == CW'(DEPTH));
        rd_ok_o = rd_en_i && !empty_w;
        pop_w   = rd_ok_o && half_sel_i;
        ovw_w   = store_i && full_w && !pop_w;
        adv_w   = store_i && !ovw_w;

        we_o    = store_i;
        waddr_o = ovw_w ? ptr_dec(st_q.wr) : st_q.wr;
        raddr_o = st_q.rd;

        st_d = st_q;
        if (adv_w) begin
            st_d.wr = ptr_inc(st_q.wr);
        end
        if (pop_w) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        case ({adv_w, pop_w})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.ready_n = (st_d.cnt == '0);
        st_d.hf_n    = (st_d.cnt < CW'(HF_LEVEL));
        st_d.full_n  = (st_d.cnt != CW'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr: '0, rd: '0, cnt: '0, ready_n: 1'b1, hf_n: 1'b1, full_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_n_o     = st_q.ready_n;
    assign half_full_n_o = st_q.hf_n;
    assign full_n_o      = st_q.full_n;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R8
    ovw_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !full_n_o && !(rd_en_i && half_sel_i)) |=> !full_n_o);

    // R10
    same_cycle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && rd_en_i && half_sel_i && !ready_n_o) |=> $stable(st_q.cnt));

    // R3
    lower_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !half_sel_i) |=> $stable(st_q.rd));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && ready_n_o) |=> $stable(st_q.rd));
endmodule

// File: rtl/rxq_dual_half_fifo.sv
module rxq_dual_half_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH    = RXQ_DEPTH,
    parameter int WORD_W   = RXQ_WORD_W,
    parameter int HF_LEVEL = DEPTH / 2,
    localparam int HALF_W  = WORD_W / 2,
    localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_i,
    input  logic [WORD_W-1:0] store_word_i,
    input  logic              rd_en_i,
    input  logic              half_sel_i,
    output logic [HALF_W-1:0] rd_data_o,
    output logic              ready_n_o,
    output logic              half_full_n_o,
    output logic              full_n_o
);
    logic              we_w, rd_ok_w;
    logic [PW-1:0]     waddr_w, raddr_w;
    logic [WORD_W-1:0] head_w;
    logic [HALF_W-1:0] out_d, out_q;

    rxq_ctrl #(.DEPTH(DEPTH), .HF_LEVEL(HF_LEVEL)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .store_i       (store_i),
        .rd_en_i       (rd_en_i),
        .half_sel_i    (half_sel_i),
        .we_o          (we_w),
        .waddr_o       (waddr_w),
        .raddr_o       (raddr_w),
        .rd_ok_o       (rd_ok_w),
        .ready_n_o     (ready_n_o),
        .half_full_n_o (half_full_n_o),
        .full_n_o      (full_n_o)
    );

    rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (store_word_i),
        .raddr_i (raddr_w),
        .rdata_o (head_w)
    );

    always_comb begin
        out_d = out_q;
        if (rd_ok_w) begin
            out_d = half_sel_i ? head_w[WORD_W-1:HALF_W] : head_w[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data_o = out_q;

    // R2
    store_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_i |=> !ready_n_o);

    // R9
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && ready_n_o) |=> $stable(rd_data_o));

    // R6
    full_implies_hf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n_o |-> (!half_full_n_o && !ready_n_o));
endmodule

// File: tb/rxq_dual_half_fifo_test.sv
module rxq_dual_half_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        store = 1'b0;
    logic [31:0] word = '0;
    logic        rd_en = 1'b0;
    logic        half = 1'b0;
    logic [15:0] rd_data;
    logic        ready_n, hf_n, full_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] mq[$];
    logic [15:0] m_data = '0;

    always #4 clk = ~clk;

    rxq_dual_half_fifo uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .store_i       (store),
        .store_word_i  (word),
        .rd_en_i       (rd_en),
        .half_sel_i    (half),
        .rd_data_o     (rd_data),
        .ready_n_o     (ready_n),
        .half_full_n_o (hf_n),
        .full_n_o      (full_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        int  n;
        bit  popd;
        if (!rst_n) begin
            mq.delete();
            m_data = '0;
        end else begin
            n = mq.size();
            popd = 1'b0;
            if (rd_en && n > 0) begin
                m_data = half ? mq[0][31:16] : mq[0][15:0];
                if (half) begin
                    void'(mq.pop_front());
                    popd = 1'b1;
                end
            end
            if (store) begin
                if (n == 32 && !popd) mq[31] = word;
                else mq.push_back(word);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_data == m_data, "R3 R4 R5 R9 data", rd_data, m_data);
            chk(ready_n == (mq.size() == 0), "R2 R11 ready", ready_n, mq.size() == 0);
            chk(hf_n == (mq.size() < 16), "R6 half-full", hf_n, mq.size() < 16);
            chk(full_n == (mq.size() != 32), "R7 full", full_n, mq.size() != 32);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input bit s, input logic [31:0] w, input bit r, input bit h);
        @(negedge clk);
        store = s; word = w; rd_en = r; half = h;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0F00 ^ (i * 32'h0101_1011) ^ (32'(i) << 24);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(ready_n && hf_n && full_n && rd_data == 16'h0, "R1 reset",
            {ready_n, hf_n, full_n, rd_data}, {3'b111, 16'h0});
        rst_n = 1'b1;
        // R9: read on empty after reset
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        // R2, R5: store five words
        for (int i = 0; i < 5; i++) step(1, pat(i), 0, 0);
        step(0, 0, 0, 0);
        // R3 then R4 on two words
        for (int i = 0; i < 2; i++) begin
            step(0, 0, 1, 0);
            step(0, 0, 1, 0);
            step(0, 0, 1, 1);
        end
        // R4 upper half alone retires a word
        step(0, 0, 1, 1);
        // R11: drain the rest
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        step(0, 0, 1, 1);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(ready_n == 1'b1, "R11 ready released", ready_n, 1);
        // R9: reads against empty after draining
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        // R6: fill to 16 then R10 at the threshold
        for (int i = 0; i < 16; i++) step(1, pat(100 + i), 0, 0);
        step(1, pat(200), 1, 1);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(hf_n == 1'b0 && full_n == 1'b1, "R10 count held at 16", {hf_n, full_n}, 2'b01);
        // R7: fill to 32
        for (int i = 0; i < 16; i++) step(1, pat(300 + i), 0, 0);
        // R8: overwrite newest twice
        step(1, 32'hDEAD_BEEF, 0, 0);
        step(1, 32'h1234_5678, 0, 0);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(full_n == 1'b0, "R8 still full after overwrite", full_n, 0);
        // R10 at capacity
        step(1, pat(400), 1, 1);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(full_n == 1'b0, "R10 count held at 32", full_n, 0);
        // drain everything with both halves, checks R5 R8 order and content
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 1, 0);
            step(0, 0, 1, 1);
        end
        step(0, 0, 1, 1);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(ready_n && hf_n && full_n, "R11 empty after drain", {ready_n, hf_n, full_n}, 3'b111);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule